// File: doc/BRIEF.md
# Write-Only Register Slave on a Two-Wire Serial Bus

The block is a two-wire serial bus (I2C) target for a display-control device. It runs on a fast system clock that oversamples both bus lines. Each line first passes through a synchroniser and a glitch filter. A condition detector then finds START, repeated START and STOP, and a byte engine handles the address, acknowledge and data phases. The engine answers to one fixed 7-bit address, 46h. The address byte reads 8Ch for writes and 8Dh for reads.

In a write message the byte after the address selects a register in a bank of sixteen 8-bit control registers. Each following byte is stored at the selected register, and the selection then advances. These registers can only be written. A read message has no register-select phase. It returns one status byte, taken from an input port and frozen when the read address is acknowledged.

An enable input gates the whole interface. While enable is low the block never pulls the data line and never acknowledges, and every control register is held at its default value.

Top module: `ctl_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal 46h is acknowledged. Bit 0 of that byte selects the direction: 0 means write and 1 means read. Any other address byte gets no acknowledge, and the rest of that message is ignored until the next START.
- R2: In a write message the first byte after the address sets an 8-bit register pointer. Each following data byte is stored in register[pointer], and the pointer then steps up by one, wrapping from 0Fh back to 00h. Every one of these bytes is acknowledged.
- R3: If the pointer is 10h or higher, data bytes are still acknowledged but are discarded. The pointer does not move, and no register changes.
- R4: A repeated START with no STOP before it begins a new address phase, so the master can set a new pointer inside one message.
- R5: After an acknowledged read address the block shifts out, most significant bit first, the value that status_i held when it decided to acknowledge. Later changes on status_i do not affect that byte. If the master acknowledges, the same latched byte is sent again. If the master does not acknowledge, the block releases the bus.
- R6: A read message leaves every control register unchanged.
- R7: A START or STOP that arrives before all eight bits of a byte have been received abandons that byte, and no register is written with it.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks (4 by default) is ignored.
- R9: While en_i is low, sda_oe_o is 0, no byte is acknowledged, and regs_o holds the defaults. The default of register i is 80h OR i. Once en_i returns high, writes work again.
- R10: sda_oe_o changes only while the filtered SCL is low.
- R11: After reset, every register holds its default value and sda_oe_o is 0.
- R12: At most one control register changes in any clock cycle while the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable; low releases the bus and restores the register defaults |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND) |
| status_i | input | 8 | Status value returned by read messages |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NREG*8 | Control register contents, register i at bits [8i+7:8i] |

## Verification
A change on a bus line reaches sda_oe_o after about eight system clocks: two synchroniser stages, the FILT_LEN filter window, the filter output register and the engine register. A stored data byte appears on regs_o about two clocks after the SCL fall that ends its eighth bit. The bench holds every SCL phase for 16 clocks. It reads the acknowledge and read bits at least 16 clocks after the edge that caused them, and reads regs_o only after a STOP followed by a further wait. For R10, read bits are sampled twice while SCL is high. A monitor counts any clock in which more than one register changes (R12).

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } link_st_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_SUB,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] reg_dflt(input int unsigned i);
        return 8'h80 | BYTE_W'(i);
    endfunction

    function automatic logic ptr_valid(input logic [BYTE_W-1:0] p, input int unsigned nreg);
        return 32'(p) < nreg;
    endfunction

    function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p,
                                                   input int unsigned nreg);
        if (32'(p) >= nreg)
            return p;
        else if (32'(p) == nreg - 1)
            return '0;
        else
            return p + 8'd1;
    endfunction

endpackage

// File: rtl/ctl_i2c_deglitch.sv
module ctl_i2c_deglitch #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic dout
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/ctl_i2c_cond.sv
module ctl_i2c_cond
    import ctl_i2c_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f && scl_q && sda_q && !sda_f;
        ev.stop  = scl_f && scl_q && !sda_q && sda_f;
        ev.rise  = scl_f && !scl_q;
        ev.fall  = !scl_f && scl_q;
    end
endmodule

// File: rtl/ctl_i2c_link.sv
module ctl_i2c_link
    import ctl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h46,
    parameter int         NREG     = 16
) (
    input  logic              clk,
    input  logic              clr,
    input  bus_ev_t           ev,
    input  logic              sda_f,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_oe_o,
    output wr_req_t           wr_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    link_st_e          st;
    rx_kind_e          kind;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] stat_q;
    logic              rd;
    logic              mnak;

    always_ff @(posedge clk) begin
        if (clr) begin
            st       <= ST_IDLE;
            kind     <= K_ADDR;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            stat_q   <= '0;
            rd       <= 1'b0;
            mnak     <= 1'b0;
            sda_oe_o <= 1'b0;
            wr_o     <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (ev.start) begin
                st       <= ST_RX;
                kind     <= K_ADDR;
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else if (ev.stop) begin
                st       <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end else if (ev.fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            bit_cnt <= '0;
                            case (kind)
                                K_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        st       <= ST_ACK;
                                        sda_oe_o <= 1'b1;
                                        rd       <= rx_sh[0];
                                        kind     <= K_SUB;
                                        if (rx_sh[0])
                                            stat_q <= status_i;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                K_SUB: begin
                                    ptr      <= rx_sh;
                                    st       <= ST_ACK;
                                    sda_oe_o <= 1'b1;
                                    kind     <= K_DATA;
                                end
                                default: begin
                                    if (ptr_valid(ptr, NREG)) begin
                                        wr_o.en   <= 1'b1;
                                        wr_o.idx  <= ptr;
                                        wr_o.data <= rx_sh;
                                    end
                                    ptr      <= ptr_step(ptr, NREG);
                                    st       <= ST_ACK;
                                    sda_oe_o <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            if (rd) begin
                                st       <= ST_TX;
                                tx_sh    <= stat_q;
                                sda_oe_o <= ~stat_q[BYTE_W-1];
                                bit_cnt  <= '0;
                            end else begin
                                st       <= ST_RX;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                st       <= ST_MACK;
                                sda_oe_o <= 1'b0;
                            end else begin
                                sda_oe_o <= ~tx_sh[BYTE_W-2];
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                bit_cnt  <= bit_cnt + CNT_W'(1);
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.rise) begin
                            mnak <= sda_f;
                        end else if (ev.fall) begin
                            if (mnak) begin
                                st <= ST_IDLE;
                            end else begin
                                st       <= ST_TX;
                                tx_sh    <= stat_q;
                                sda_oe_o <= ~stat_q[BYTE_W-1];
                                bit_cnt  <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
    import ctl_i2c_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                   clk,
    input  logic                   clr,
    input  wr_req_t                wr,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [BYTE_W-1:0] r;
        always_ff @(posedge clk) begin
            if (clr)
                r <= reg_dflt(g);
            else if (wr.en && wr.idx == BYTE_W'(g))
                r <= wr.data;
        end
        assign regs_o[g*BYTE_W +: BYTE_W] = r;
    end
endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
    import ctl_i2c_pkg::*;
#(
    parameter int         NREG     = 16,
    parameter int         FILT_LEN = 4,
    parameter logic [6:0] DEV_ADDR = 7'h46
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en_i,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic [BYTE_W-1:0]      status_i,
    output logic                   sda_oe_o,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    localparam int NLINE = 2;

    logic             clr;
    logic [NLINE-1:0] raw, filt;
    logic             scl_f, sda_f;
    bus_ev_t          ev;
    wr_req_t          wr;

    assign clr = rst | ~en_i;
    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_flt
        ctl_i2c_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk (clk),
            .clr (clr),
            .din (raw[g]),
            .dout(filt[g])
        );
    end

    assign scl_f = filt[1];
    assign sda_f = filt[0];

    ctl_i2c_cond u_cond (
        .clk  (clk),
        .clr  (clr),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .ev   (ev)
    );

    ctl_i2c_link #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_link (
        .clk     (clk),
        .clr     (clr),
        .ev      (ev),
        .sda_f   (sda_f),
        .status_i(status_i),
        .sda_oe_o(sda_oe_o),
        .wr_o    (wr)
    );

    ctl_i2c_regbank #(.NREG(NREG)) u_bank (
        .clk   (clk),
        .clr   (clr),
        .wr    (wr),
        .regs_o(regs_o)
    );
endmodule

// File: rtl/ctl_i2c_target_chk.sv
module ctl_i2c_target_chk
    import ctl_i2c_pkg::*;
#(
    parameter int NREG = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   en_i,
    input logic                   scl_f,
    input logic                   sda_oe_o,
    input logic [NREG*BYTE_W-1:0] regs_o
);
    logic [NREG*BYTE_W-1:0] dflt;
    logic [NREG*BYTE_W-1:0] regs_q;
    logic [NREG-1:0]        chg;

    for (genvar g = 0; g < NREG; g++) begin : g_d
        assign dflt[g*BYTE_W +: BYTE_W] = reg_dflt(g);
        assign chg[g] = regs_o[g*BYTE_W +: BYTE_W] != regs_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) regs_q <= regs_o;

    a_r9_disabled_release: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !sda_oe_o);

    a_r9_disabled_defaults: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> regs_o == dflt);

    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && !$stable(sda_oe_o)) |-> !$past(scl_f));

    a_r12_one_reg_per_cycle: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && !$past(rst)) |-> $countones(chg) <= 1);
endmodule

bind ctl_i2c_target ctl_i2c_target_chk #(.NREG(NREG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .scl_f   (scl_f),
    .sda_oe_o(sda_oe_o),
    .regs_o  (regs_o)
);

// File: tb/sim_ctl_i2c_target.sv
`timescale 1ns/1ps
module sim_ctl_i2c_target;
    localparam int NREG = 16;
    localparam int Q    = 16;

    logic                clk = 1'b0;
    logic                rst, en, scl_m, sda_m;
    logic [7:0]          status;
    logic                sda_oe;
    logic [NREG*8-1:0]   regs;
    wire                 sda_line = sda_m & ~sda_oe;

    logic [7:0] exp_r [NREG];
    logic [7:0] mptr;
    int n_chk = 0, n_bad = 0, multi_chg = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl_i2c_target #(.NREG(NREG)) u0 (
        .clk(clk), .rst(rst), .en_i(en), .scl_i(scl_m), .sda_i(sda_line),
        .status_i(status), .sda_oe_o(sda_oe), .regs_o(regs)
    );

    logic [NREG*8-1:0] regs_prev;
    logic              en_prev;
    always @(posedge clk) begin
        int c;
        c = 0;
        for (int i = 0; i < NREG; i++)
            if (regs[i*8 +: 8] !== regs_prev[i*8 +: 8]) c++;
        if (!rst && en && en_prev && c > 1) multi_chg++;
        regs_prev <= regs;
        en_prev   <= en;
    end

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++)
            check(tag, {24'd0, regs[i*8 +: 8]}, {24'd0, exp_r[i]});
    endtask

    task automatic model_defaults();
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h80 | 8'(i);
    endtask

    task automatic model_byte(input logic [7:0] d);
        if (mptr < 8'(NREG)) begin
            exp_r[mptr] = d;
            mptr = (mptr == 8'(NREG - 1)) ? 8'd0 : mptr + 8'd1;
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b0; wait_c(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_c(Q);
        scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b0; wait_c(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b1; wait_c(Q);
    endtask

    task automatic put_bit(input logic b, input int gl);
        sda_m = b;
        if (gl == 2) begin
            wait_c(6); scl_m = 1'b1; wait_c(2); scl_m = 1'b0; wait_c(Q - 8);
        end else begin
            wait_c(Q);
        end
        scl_m = 1'b1; wait_c(Q);
        if (gl == 1) begin
            sda_m = ~b; wait_c(2); sda_m = b; wait_c(Q - 2);
        end else begin
            wait_c(Q);
        end
        scl_m = 1'b0; wait_c(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int gl, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i], gl);
        sda_m = 1'b1; wait_c(Q);
        scl_m = 1'b1; wait_c(Q);
        ack = (sda_line == 1'b0);
        wait_c(Q);
        scl_m = 1'b0; wait_c(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nak);
        logic s1, s2;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_c(Q);
            scl_m = 1'b1; wait_c(Q);
            s1 = sda_line;
            wait_c(Q - 2);
            s2 = sda_line;
            check("R10 read bit steady while SCL high", {31'd0, s2}, {31'd0, s1});
            b[i] = s1;
            wait_c(2);
            scl_m = 1'b0;
        end
        wait_c(Q);
        sda_m = nak; wait_c(Q);
        scl_m = 1'b1; wait_c(2 * Q);
        scl_m = 1'b0; wait_c(Q);
        sda_m = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        logic [7:0] sv [4];
        sv[0] = 8'h5A; sv[1] = 8'h00; sv[2] = 8'hFF; sv[3] = 8'h81;

        rst = 1'b1; en = 1'b1; scl_m = 1'b1; sda_m = 1'b1; status = 8'h00;
        regs_prev = '0; en_prev = 1'b0;
        wait_c(10);
        rst = 1'b0;
        wait_c(5);
        model_defaults();
        mptr = 8'd0;
        check_regs("R11 reset defaults");
        check("R11 sda released after reset", {31'd0, sda_oe}, 32'd0);

        // R2: sweep every start pointer, two data bytes each (covers wrap)
        for (int s = 0; s < NREG; s++) begin
            bus_start();
            send_byte(8'h8C, 0, ack); check("R1 write address ack", {31'd0, ack}, 32'd1);
            send_byte(8'(s), 0, ack); check("R2 pointer ack", {31'd0, ack}, 32'd1);
            mptr = 8'(s);
            send_byte(8'(s * 7 + 1), 0, ack); check("R2 data ack", {31'd0, ack}, 32'd1);
            model_byte(8'(s * 7 + 1));
            send_byte(8'(s * 13 + 5), 0, ack); check("R2 data ack", {31'd0, ack}, 32'd1);
            model_byte(8'(s * 13 + 5));
            bus_stop();
            wait_c(4 * Q);
            check_regs("R2 auto-increment write");
        end

        // R1: foreign addresses are not acknowledged and the message is ignored
        bus_start();
        send_byte(8'h8E, 0, ack); check("R1 foreign address nak", {31'd0, ack}, 32'd0);
        send_byte(8'h00, 0, ack); check("R1 ignored byte nak", {31'd0, ack}, 32'd0);
        send_byte(8'h55, 0, ack);
        bus_stop();
        bus_start();
        send_byte(8'h46, 0, ack); check("R1 7-bit form not matched", {31'd0, ack}, 32'd0);
        bus_stop();
        wait_c(4 * Q);
        check_regs("R1 no write from foreign address");

        // R3: pointer out of range
        foreach (sv[k]) begin
            bus_start();
            send_byte(8'h8C, 0, ack);
            send_byte(8'h10 + 8'(k * 60), 0, ack);
            send_byte(8'h11 + 8'(k), 0, ack); check("R3 out-of-range data ack", {31'd0, ack}, 32'd1);
            send_byte(8'h22, 0, ack); check("R3 out-of-range data ack", {31'd0, ack}, 32'd1);
            bus_stop();
            wait_c(4 * Q);
            check_regs("R3 discarded data");
        end

        // R4: repeated START sets a new pointer inside one message
        bus_start();
        send_byte(8'h8C, 0, ack);
        send_byte(8'h05, 0, ack); mptr = 8'h05;
        send_byte(8'hA1, 0, ack); model_byte(8'hA1);
        bus_rstart();
        send_byte(8'h8C, 0, ack); check("R4 address after repeated start", {31'd0, ack}, 32'd1);
        send_byte(8'h09, 0, ack); mptr = 8'h09;
        send_byte(8'hB2, 0, ack); model_byte(8'hB2);
        bus_stop();
        wait_c(4 * Q);
        check_regs("R4 repeated start write");

        // R7: START and STOP inside a byte abandon it
        bus_start();
        send_byte(8'h8C, 0, ack);
        send_byte(8'h02, 0, ack);
        for (int i = 7; i >= 4; i--) put_bit(1'(8'h3C >> i), 0);
        bus_rstart();
        send_byte(8'h8C, 0, ack);
        send_byte(8'h07, 0, ack); mptr = 8'h07;
        send_byte(8'h77, 0, ack); model_byte(8'h77);
        bus_stop();
        bus_start();
        send_byte(8'h8C, 0, ack);
        send_byte(8'h04, 0, ack);
        for (int i = 7; i >= 5; i--) put_bit(1'(8'hE1 >> i), 0);
        bus_stop();
        wait_c(4 * Q);
        check_regs("R7 partial byte not committed");

        // R5/R6: status read, latched at address ack, repeated on master ack
        foreach (sv[k]) begin
            status = sv[k];
            bus_start();
            send_byte(8'h8D, 0, ack); check("R5 read address ack", {31'd0, ack}, 32'd1);
            status = ~sv[k];
            recv_byte(rb, 1'b0); check("R5 latched status", {24'd0, rb}, {24'd0, sv[k]});
            recv_byte(rb, 1'b1); check("R5 repeat after master ack", {24'd0, rb}, {24'd0, sv[k]});
            bus_stop();
            wait_c(2 * Q);
            check("R5 bus released after nak", {31'd0, sda_oe}, 32'd0);
            check_regs("R6 read leaves registers");
        end

        // R8: short pulses on SDA while SCL high, then on SCL while low
        bus_start();
        send_byte(8'h8C, 1, ack); check("R8 sda glitch address ack", {31'd0, ack}, 32'd1);
        send_byte(8'h0B, 1, ack); mptr = 8'h0B;
        send_byte(8'h69, 1, ack); model_byte(8'h69);
        bus_stop();
        bus_start();
        send_byte(8'h8C, 2, ack); check("R8 scl glitch address ack", {31'd0, ack}, 32'd1);
        send_byte(8'h0C, 2, ack); mptr = 8'h0C;
        send_byte(8'h96, 2, ack); model_byte(8'h96);
        bus_stop();
        wait_c(4 * Q);
        check_regs("R8 glitches ignored");

        // R9: disable restores defaults and silences the interface
        en = 1'b0;
        wait_c(3);
        model_defaults();
        check_regs("R9 defaults while disabled");
        bus_start();
        send_byte(8'h8C, 0, ack); check("R9 no ack while disabled", {31'd0, ack}, 32'd0);
        send_byte(8'h01, 0, ack);
        send_byte(8'h44, 0, ack);
        bus_stop();
        check("R9 sda released while disabled", {31'd0, sda_oe}, 32'd0);
        en = 1'b1;
        wait_c(Q);
        check_regs("R9 no write while disabled");
        bus_start();
        send_byte(8'h8C, 0, ack); check("R9 ack after re-enable", {31'd0, ack}, 32'd1);
        send_byte(8'h01, 0, ack); mptr = 8'h01;
        send_byte(8'h44, 0, ack); model_byte(8'h44);
        bus_stop();
        wait_c(4 * Q);
        check_regs("R9 write after re-enable");

        check("R12 at most one register per clock", multi_chg, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule